// File: doc/BRIEF.md
# Flash Row Programming Controller

This block lets a processor reprogram its own 24-bit program flash one row at a time. Software sends table writes. Each write carries an effective address and a 16-bit value. A low-half write fills bits 15:0 of one instruction word in a row-sized staging buffer. A high-half write fills the upper byte of that word. Every table write also records its effective address in two address registers. The flash itself is not touched until a program or erase cycle runs.

A cycle is guarded by a key register that can only be written. Software writes 0x55 and then 0xAA to it on back-to-back register writes. The next control write with the start bit set then launches the cycle. While the cycle runs, the controller drives the flash array port once per clock for each word of the selected row. A program cycle sends the staged words. An erase cycle sends all ones. At the end the controller drops busy, clears start and pulses done.

The staging buffer accepts data for only one row between cycles. A table write aimed at any other row is refused and raises an alignment error. A program request made while that error is set is rejected.

Top module: `flash_row_ctl`

## Requirements
- R1: A low table write stores tbl_data into bits 15:0 of staged word tbl_addr[5:1]. A high table write stores tbl_data[7:0] into bits 23:16 of that word. A program cycle sends each staged word to the array unchanged.
- R2: Each accepted table write loads its tbl_addr[15:0] into the low address register and tbl_addr[23:16] into the high address register. These registers are also writable. rd_sel 1 reads the low register, and rd_sel 2 reads the high register zero-extended.
- R3: The key register (reg_sel 3) always reads as zero through rd_sel 3.
- R4: A register write of 0x55 to the key, followed by 0xAA as the very next register write, arms the block. The register write after that, if it is a control write (reg_sel 0) with bit 0 (start) set, launches a cycle. busy is readable as control bit 4 and start as control bit 0.
- R5: The arm is lost if any other register write comes between or after the two key values, or if a wrong key value is written. A start request made while not armed launches nothing and sets the key-error flag (control bit 2).
- R6: Once a cycle starts, busy stays high for exactly 32 clocks. During those clocks fl_we writes row words 0 to 31 in ascending order, at fl_addr = {address register bits 23:6, word index}. After that, busy and start are low, and done is high for one clock.
- R7: Control bit 1 selects erase. An erase cycle writes 24'hFFFFFF to every word of the row.
- R8: Table writes and register writes received while busy leave every register and the staged data unchanged.
- R9: At reset, and after each completed program cycle, every staged word is all ones. A word that was never loaded is programmed as all ones.
- R10: The first accepted table write after reset or after a completed cycle fixes the row. A table write to a different row stores no data and sets the alignment-error flag (control bit 3). A program start made while that flag is set is rejected, with no busy.
- R11: A control write with bit 2 or bit 3 clear clears the matching error flag. Clearing the alignment error also frees the row choice for the next table write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_lo | input | 1 | Low-half table write strobe |
| tbl_wr_hi | input | 1 | High-half table write strobe |
| tbl_addr | input | 24 | Effective address of the table write |
| tbl_data | input | 16 | Table write data |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address low, 2 address high, 3 key |
| reg_wdata | input | 16 | Register write data |
| rd_sel | input | 2 | Register read select, same coding as reg_sel |
| rd_data | output | 16 | Register read data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock pulse when a cycle ends |
| fl_we | output | 1 | Flash array write enable |
| fl_addr | output | 23 | Flash array word address |
| fl_wdata | output | 24 | Flash array write data |

## Verification
The bench builds the block with its default parameters: 32 words of 24 bits per row, so the word index is address bits 5:1 and the row starts at bit 6. These values make a full-row cycle finish well inside the run. They also let the scenarios move across upper-address values 0x01, 0x02, 0x05 and 0x06, which crosses panel boundaries and places rows in different panels for the alignment-error case. A partly loaded row, a word loaded only in its low half, and a back-to-back program with no new loads exercise the all-ones rules at word and row level.

// File: rtl/flash_row_pkg.sv
package flash_row_pkg;

    localparam int ADDR_W = 24;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_ADR_LO = 2'd1,
        SEL_ADR_HI = 2'd2,
        SEL_KEY    = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ARM_IDLE = 2'd0,
        ARM_HALF = 2'd1,
        ARM_FULL = 2'd2
    } arm_e;

    localparam logic [HALF_W-1:0] KEY_FIRST  = 16'h0055;
    localparam logic [HALF_W-1:0] KEY_SECOND = 16'h00AA;

    localparam int CB_START = 0;
    localparam int CB_ERASE = 1;
    localparam int CB_KERR  = 2;
    localparam int CB_AERR  = 3;

    // Field order is the control read layout, bit 4 down to bit 0.
    typedef struct packed {
        logic busy;
        logic align_err;
        logic key_err;
        logic erase;
        logic start;
    } ctrl_view_t;

    function automatic logic [HALF_W-1:0] ctrl_word(ctrl_view_t c);
        return {{(HALF_W-$bits(ctrl_view_t)){1'b0}}, c};
    endfunction

endpackage

// File: rtl/frc_unlock.sv
module frc_unlock
    import flash_row_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [HALF_W-1:0] wdata,
    output logic              armed
);
    arm_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARM_IDLE;
        end else if (wr_en) begin
            if (sel != SEL_KEY)                                  state_q <= ARM_IDLE;
            else if (wdata == KEY_FIRST)                         state_q <= ARM_HALF;
            else if (state_q == ARM_HALF && wdata == KEY_SECOND) state_q <= ARM_FULL;
            else                                                 state_q <= ARM_IDLE;
        end
    end

    assign armed = (state_q == ARM_FULL);
endmodule

// File: rtl/frc_row_latch.sv
module frc_row_latch
    import flash_row_pkg::*;
#(
    parameter int WORDS  = 32,
    parameter int WORD_W = 24,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    localparam int HI_W = WORD_W - HALF_W;

    logic [WORD_W-1:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                mem[g] <= '1;
            end else if (wr_idx == IDX_W'(g)) begin
                if (wr_lo) mem[g][HALF_W-1:0]      <= wr_data;
                if (wr_hi) mem[g][WORD_W-1:HALF_W] <= wr_data[HI_W-1:0];
            end
        end
    end

    assign rd_word = mem[rd_idx];
endmodule

// File: rtl/frc_sequencer.sv
module frc_sequencer #(
    parameter int WORDS = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    output logic             busy,
    output logic             done,
    output logic             finishing,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    assign finishing = busy && (idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            idx  <= '0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                busy <= 1'b1;
                idx  <= '0;
            end else if (finishing) begin
                busy <= 1'b0;
                done <= 1'b1;
                idx  <= '0;
            end else if (busy) begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/flash_row_ctl.sv
module flash_row_ctl
    import flash_row_pkg::*;
#(
    parameter int WORDS_PER_ROW = 32,
    parameter int WORD_W        = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_wr_lo,
    input  logic              tbl_wr_hi,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [HALF_W-1:0] tbl_data,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [HALF_W-1:0] reg_wdata,
    input  logic [1:0]        rd_sel,
    output logic [HALF_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              fl_we,
    output logic [ADDR_W-2:0] fl_addr,
    output logic [WORD_W-1:0] fl_wdata
);
    localparam int IDX_W   = $clog2(WORDS_PER_ROW);
    localparam int ROW_LSB = IDX_W + 1;
    localparam int ROW_W   = ADDR_W - ROW_LSB;

    logic [ADDR_W-1:0] adr_q;
    logic              erase_q, start_q, key_err_q, align_err_q;
    logic              anchor_v;
    logic [ROW_W-1:0]  anchor_row;

    logic              armed, finishing;
    logic [IDX_W-1:0]  seq_idx;
    logic [WORD_W-1:0] latch_word;

    reg_sel_e          wsel;
    logic [ROW_W-1:0]  tbl_row;
    logic [IDX_W-1:0]  tbl_idx;
    logic              tbl_any, row_bad, reg_ok, ctrl_wr, go_req, launch;

    assign wsel    = reg_sel_e'(reg_sel);
    assign tbl_row = tbl_addr[ADDR_W-1:ROW_LSB];
    assign tbl_idx = tbl_addr[ROW_LSB-1:1];
    assign tbl_any = (tbl_wr_lo || tbl_wr_hi) && !busy;
    assign row_bad = anchor_v && (tbl_row != anchor_row);
    assign reg_ok  = reg_wr && !busy;
    assign ctrl_wr = reg_ok && (wsel == SEL_CTRL);
    assign go_req  = ctrl_wr && reg_wdata[CB_START];
    assign launch  = go_req && armed && !(align_err_q && !reg_wdata[CB_ERASE]);

    frc_unlock u_unlock (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_ok),
        .sel   (wsel),
        .wdata (reg_wdata),
        .armed (armed)
    );

    frc_row_latch #(.WORDS(WORDS_PER_ROW), .WORD_W(WORD_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .flush   (finishing && !erase_q),
        .wr_lo   (tbl_wr_lo && !busy && !row_bad),
        .wr_hi   (tbl_wr_hi && !busy && !row_bad),
        .wr_idx  (tbl_idx),
        .wr_data (tbl_data),
        .rd_idx  (seq_idx),
        .rd_word (latch_word)
    );

    frc_sequencer #(.WORDS(WORDS_PER_ROW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .busy      (busy),
        .done      (done),
        .finishing (finishing),
        .idx       (seq_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            adr_q       <= '0;
            erase_q     <= 1'b0;
            start_q     <= 1'b0;
            key_err_q   <= 1'b0;
            align_err_q <= 1'b0;
            anchor_v    <= 1'b0;
            anchor_row  <= '0;
        end else begin
            if (tbl_any) begin
                adr_q <= tbl_addr;
                if (row_bad) begin
                    align_err_q <= 1'b1;
                end else if (!anchor_v) begin
                    anchor_v   <= 1'b1;
                    anchor_row <= tbl_row;
                end
            end
            if (reg_ok && wsel == SEL_ADR_LO) adr_q[HALF_W-1:0]      <= reg_wdata;
            if (reg_ok && wsel == SEL_ADR_HI) adr_q[ADDR_W-1:HALF_W] <= reg_wdata[ADDR_W-HALF_W-1:0];
            if (ctrl_wr) begin
                erase_q <= reg_wdata[CB_ERASE];
                if (!reg_wdata[CB_KERR]) key_err_q <= 1'b0;
                if (!reg_wdata[CB_AERR]) begin
                    align_err_q <= 1'b0;
                    anchor_v    <= 1'b0;
                end
                if (go_req && !armed) key_err_q <= 1'b1;
                if (launch) start_q <= 1'b1;
            end
            if (finishing) begin
                start_q  <= 1'b0;
                anchor_v <= 1'b0;
            end
        end
    end

    assign fl_we    = busy;
    assign fl_addr  = {adr_q[ADDR_W-1:ROW_LSB], seq_idx};
    assign fl_wdata = erase_q ? '1 : latch_word;

    ctrl_view_t view;
    assign view = '{busy: busy, align_err: align_err_q, key_err: key_err_q,
                    erase: erase_q, start: start_q};

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_CTRL:   rd_data = ctrl_word(view);
            SEL_ADR_LO: rd_data = adr_q[HALF_W-1:0];
            SEL_ADR_HI: rd_data = {{(2*HALF_W-ADDR_W){1'b0}}, adr_q[ADDR_W-1:HALF_W]};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
    parameter int WORDS  = 32,
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              fl_we,
    input logic [WORD_W-1:0] fl_wdata,
    input logic              erase_q,
    input logic              armed,
    input logic [23:0]       adr_q,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [15:0]       reg_wdata,
    input logic              tbl_wr_lo,
    input logic              tbl_wr_hi,
    input logic [1:0]        rd_sel,
    input logic [15:0]       rd_data
);
    int run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    p_key_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        rd_sel == 2'd3 |-> rd_data == 16'h0000);

    p_start_needs_arm_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && reg_wr && reg_sel == 2'd0 && reg_wdata[0] && !armed) |=> !busy);

    p_busy_length_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_len == WORDS);

    p_done_after_busy_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    p_write_in_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        fl_we |-> busy);

    p_erase_ones_r7: assert property (@(posedge clk) disable iff (rst)
        (fl_we && erase_q) |-> (&fl_wdata));

    p_busy_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && (tbl_wr_lo || tbl_wr_hi || reg_wr)) |=> ($stable(adr_q) && $stable(erase_q)));
endmodule

bind flash_row_ctl frc_checker #(.WORDS(WORDS_PER_ROW), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .fl_we     (fl_we),
    .fl_wdata  (fl_wdata),
    .erase_q   (erase_q),
    .armed     (armed),
    .adr_q     (adr_q),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .tbl_wr_lo (tbl_wr_lo),
    .tbl_wr_hi (tbl_wr_hi),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data)
);

// File: tb/flash_row_ctl_tb.sv
module flash_row_ctl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_wr_lo = 1'b0, tbl_wr_hi = 1'b0;
    logic [23:0] tbl_addr = '0;
    logic [15:0] tbl_data = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        busy, done, fl_we;
    logic [22:0] fl_addr;
    logic [23:0] fl_wdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    flash_row_ctl u_dut (
        .clk(clk), .rst(rst),
        .tbl_wr_lo(tbl_wr_lo), .tbl_wr_hi(tbl_wr_hi), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .busy(busy), .done(done),
        .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata)
    );

    // Behavioural flash array
    logic [23:0] flash_mem [int];
    always @(posedge clk) if (fl_we) flash_mem[int'(fl_addr)] = fl_wdata;

    function automatic logic [23:0] mem_at(logic [23:0] ea);
        int k = int'(ea[23:1]);
        return flash_mem.exists(k) ? flash_mem[k] : 24'h000000;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state
    bit [23:0] m_lat [32];
    bit [23:0] m_adr;
    int        m_arm;
    bit        m_erase, m_start, m_kerr, m_aerr, m_anc_v, m_busy, m_done;
    bit [17:0] m_anc;
    int        m_cnt;

    task automatic model_step();
        bit [17:0] row;
        int        ix;
        bit        was_armed, old_aerr;
        if (rst) begin
            foreach (m_lat[i]) m_lat[i] = 24'hFFFFFF;
            m_adr = 0; m_arm = 0; m_erase = 0; m_start = 0; m_kerr = 0; m_aerr = 0;
            m_anc_v = 0; m_anc = 0; m_busy = 0; m_done = 0; m_cnt = 0;
            return;
        end
        m_done = 0;
        if (m_busy) begin
            if (m_cnt == 31) begin
                m_busy = 0; m_start = 0; m_done = 1; m_anc_v = 0; m_cnt = 0;
                if (!m_erase) foreach (m_lat[i]) m_lat[i] = 24'hFFFFFF;
            end else begin
                m_cnt++;
            end
            return;
        end
        if (tbl_wr_lo || tbl_wr_hi) begin
            row = tbl_addr[23:6];
            ix  = int'(tbl_addr[5:1]);
            if (m_anc_v && row != m_anc) m_aerr = 1;
            else begin
                if (!m_anc_v) begin m_anc_v = 1; m_anc = row; end
                if (tbl_wr_lo) m_lat[ix][15:0]  = tbl_data;
                if (tbl_wr_hi) m_lat[ix][23:16] = tbl_data[7:0];
            end
            m_adr = tbl_addr;
        end
        if (reg_wr) begin
            case (reg_sel)
                2'd0: begin
                    was_armed = (m_arm == 2);
                    old_aerr  = m_aerr;
                    m_erase   = reg_wdata[1];
                    if (!reg_wdata[2]) m_kerr = 0;
                    if (!reg_wdata[3]) begin m_aerr = 0; m_anc_v = 0; end
                    if (reg_wdata[0]) begin
                        if (!was_armed) m_kerr = 1;
                        else if (!(old_aerr && !reg_wdata[1])) begin
                            m_start = 1; m_busy = 1; m_cnt = 0;
                        end
                    end
                    m_arm = 0;
                end
                2'd1: begin m_adr[15:0]  = reg_wdata;      m_arm = 0; end
                2'd2: begin m_adr[23:16] = reg_wdata[7:0]; m_arm = 0; end
                default: begin
                    if (reg_wdata == 16'h0055)                   m_arm = 1;
                    else if (m_arm == 1 && reg_wdata == 16'h00AA) m_arm = 2;
                    else                                          m_arm = 0;
                end
            endcase
        end
    endtask

    task automatic model_compare();
        logic [15:0] exp_rd;
        string       rtag;
        case (rd_sel)
            2'd0: begin exp_rd = {11'b0, m_busy, m_aerr, m_kerr, m_erase, m_start}; rtag = "R5 ctrl read"; end
            2'd1: begin exp_rd = m_adr[15:0];          rtag = "R2 adr lo read"; end
            2'd2: begin exp_rd = {8'h00, m_adr[23:16]}; rtag = "R2 adr hi read"; end
            default: begin exp_rd = 16'h0000;          rtag = "R3 key read"; end
        endcase
        check("R6 busy", 32'(busy), 32'(m_busy));
        check("R6 done", 32'(done), 32'(m_done));
        check("R6 fl_we", 32'(fl_we), 32'(m_busy));
        check(rtag, 32'(rd_data), 32'(exp_rd));
        if (m_busy) begin
            check("R6 fl_addr", 32'(fl_addr), 32'({m_adr[23:6], 5'(m_cnt)}));
            check(m_erase ? "R7 fl_wdata" : "R1 fl_wdata", 32'(fl_wdata),
                  32'(m_erase ? 24'hFFFFFF : m_lat[m_cnt]));
        end
    endtask

    always @(posedge clk) begin
        model_step();
        #2;
        model_compare();
    end

    // Stimulus tasks
    task automatic tbl_lo(logic [23:0] a, logic [15:0] d);
        @(negedge clk); tbl_wr_lo = 1'b1; tbl_addr = a; tbl_data = d;
        @(negedge clk); tbl_wr_lo = 1'b0;
    endtask

    task automatic tbl_hi(logic [23:0] a, logic [15:0] d);
        @(negedge clk); tbl_wr_hi = 1'b1; tbl_addr = a; tbl_data = d;
        @(negedge clk); tbl_wr_hi = 1'b0;
    endtask

    task automatic regw(logic [1:0] s, logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic unlock();
        regw(2'd3, 16'h0055);
        regw(2'd3, 16'h00AA);
    endtask

    task automatic chk_rd(logic [1:0] s, logic [15:0] exp, string tag);
        @(negedge clk); rd_sel = s; #1;
        check(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic wait_done();
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    localparam logic [23:0] ROW_A = 24'h010140;
    localparam logic [23:0] ROW_B = 24'h020000;
    localparam logic [23:0] ROW_C = 24'h050000;
    localparam logic [23:0] ROW_D = 24'h060000;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // Reset state
        chk_rd(2'd0, 16'h0000, "R6 reset ctrl");
        chk_rd(2'd1, 16'h0000, "R2 reset adr lo");
        chk_rd(2'd3, 16'h0000, "R3 reset key");

        // Program row A, word 7 left unloaded
        for (int i = 0; i < 32; i++) begin
            if (i != 7) begin
                tbl_lo(ROW_A + 24'(2 * i), 16'h1000 + 16'(i));
                tbl_hi(ROW_A + 24'(2 * i), 16'h0040 + 16'(i));
            end
        end
        chk_rd(2'd1, 16'h017E, "R2 captured adr lo");
        chk_rd(2'd2, 16'h0001, "R2 captured adr hi");
        unlock();
        regw(2'd0, 16'h0001);
        chk_rd(2'd0, 16'h0011, "R4 busy and start after unlock");
        wait_done();
        for (int i = 0; i < 32; i++) begin
            check(i == 7 ? "R9 unloaded word" : "R1 programmed word",
                  32'(mem_at(ROW_A + 24'(2 * i))),
                  32'(i == 7 ? 24'hFFFFFF : {8'h40 + 8'(i), 16'h1000 + 16'(i)}));
        end

        // Writes during busy are ignored
        tbl_lo(ROW_B, 16'hBEEF); tbl_hi(ROW_B, 16'h0012);
        tbl_lo(ROW_B + 24'd2, 16'hCAFE);
        unlock();
        regw(2'd0, 16'h0001);
        tbl_lo(24'h030000, 16'h5555);
        regw(2'd1, 16'h1234);
        regw(2'd0, 16'h0002);
        wait_done();
        chk_rd(2'd1, 16'h0002, "R8 adr lo unchanged");
        chk_rd(2'd2, 16'h0002, "R8 adr hi unchanged");
        chk_rd(2'd0, 16'h0000, "R8 ctrl unchanged");
        check("R1 row B word0", 32'(mem_at(ROW_B)), 32'(24'h12BEEF));
        check("R9 row B half-loaded word1", 32'(mem_at(ROW_B + 24'd2)), 32'(24'hFFCAFE));
        check("R9 row B word2", 32'(mem_at(ROW_B + 24'd4)), 32'(24'hFFFFFF));

        // Latch flushed after program
        unlock();
        regw(2'd0, 16'h0001);
        wait_done();
        check("R9 latch reset after program", 32'(mem_at(ROW_B)), 32'(24'hFFFFFF));

        // Erase row A
        regw(2'd1, 16'h0140);
        regw(2'd2, 16'h0001);
        unlock();
        regw(2'd0, 16'h0003);
        wait_done();
        check("R7 erase word0", 32'(mem_at(ROW_A)), 32'(24'hFFFFFF));
        check("R7 erase word31", 32'(mem_at(ROW_A + 24'd62)), 32'(24'hFFFFFF));
        chk_rd(2'd0, 16'h0002, "R6 start cleared after erase");

        // Broken unlock sequences
        regw(2'd3, 16'h0055);
        regw(2'd1, 16'h0140);
        regw(2'd3, 16'h00AA);
        regw(2'd0, 16'h0001);
        chk_rd(2'd0, 16'h0004, "R5 interrupted key");
        regw(2'd0, 16'h0000);
        chk_rd(2'd0, 16'h0000, "R11 key error cleared");
        regw(2'd3, 16'h0055);
        regw(2'd3, 16'h00AB);
        regw(2'd3, 16'h00AA);
        chk_rd(2'd3, 16'h0000, "R3 key after writes");
        regw(2'd0, 16'h0001);
        chk_rd(2'd0, 16'h0004, "R5 wrong key value");
        regw(2'd0, 16'h0000);

        // Misaligned table write
        tbl_lo(ROW_C + 24'd4, 16'hAAAA);
        tbl_lo(ROW_D + 24'd6, 16'hBBBB);
        chk_rd(2'd0, 16'h0008, "R10 align error set");
        regw(2'd1, 16'h0000);
        regw(2'd2, 16'h0005);
        unlock();
        regw(2'd0, 16'h0009);
        chk_rd(2'd0, 16'h0008, "R10 program rejected");
        regw(2'd0, 16'h0000);
        chk_rd(2'd0, 16'h0000, "R11 align error cleared");
        unlock();
        regw(2'd0, 16'h0001);
        wait_done();
        check("R10 anchored word kept", 32'(mem_at(ROW_C + 24'd4)), 32'(24'hFFAAAA));
        check("R10 refused word not stored", 32'(mem_at(ROW_C + 24'd6)), 32'(24'hFFFFFF));

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog run did not end");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule